// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers interrupt requests from three core sources (reset, emulation, power-down) and a parameterised set of peripheral sources into a pending latch. Software can read the latch and overwrite it to force or withdraw requests. The latch is filtered by a mask register and by a global enable. The highest-ranked request that survives is presented to the core as a registered request flag with a source index.

The core answers with a one-cycle acknowledge. This clears the chosen pending bit and records that source's rank as the level now in service. A one-cycle return strobe restores the level that was in service before, taken from an internal stack. A nesting bit in the control register selects between two modes. With nesting on, only a strictly higher-ranked request may preempt the one in service. With nesting off, nothing is raised until the current service returns.

Source IDs are fixed: 0 is reset, 1 is emulation, 2 is power-down, and peripheral k sits at ID 3+k. Reset, emulation and power-down rank 0, 1 and 2. Peripheral k ranks 3+min(k, MAXLVL), so the last few peripherals share the lowest level. A lower rank value means a higher priority.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset `irq_req` is 0 and the latch (address 0), mask (address 1) and control (address 2) registers all read 0, so servicing starts disabled.
- R2: A pending peripheral request is raised only while its mask bit (bit = source ID) is 1; setting the mask bit later raises it.
- R3: Reset (ID 0) and emulation (ID 1) requests are raised even when their mask bits and the global enable are 0.
- R4: The power-down request (ID 2) ignores its mask bit, but it is held back while the global enable is 0 and is raised once the enable is set.
- R5: While the global enable (control bit 5) is 0, no peripheral request is raised, and its pending bit stays set.
- R6: Among eligible requests the lowest rank wins. Between equal ranks the lower source ID wins.
- R7: Only control bits 5 (global enable) and 4 (nesting enable) are stored. Every other control bit reads back 0 whatever was written.
- R8: A write to the latch address replaces the pending bits, which can force a request pending or clear it.
- R9: An acknowledge while `irq_req` is 1 clears the pending bit of `irq_vec`, and `irq_req` is 0 in the following cycle.
- R10: With nesting enabled, while a source is in service only a request of strictly lower rank value is raised.
- R11: With nesting disabled, no request is raised while any source is in service.
- R12: A return strobe restores the in-service level that was in force before the latest acknowledge. When the stack empties, servicing is idle.
- R13: A hardware request in the same cycle as a latch write or an acknowledge clear stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NSRC | Request inputs, one per source ID; a 1 sets the pending bit |
| reg_addr | input | 2 | Register select: 0 latch, 1 mask, 2 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data of the register selected in the previous cycle |
| core_ack | input | 1 | Core takes the presented request |
| core_ret | input | 1 | Core leaves the current service routine |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | VW | Source ID of the presented request |

## Verification
The assertions assume the core raises `core_ack` only while `irq_req` is 1. They also assume `core_ack` and `core_ret` never occur in the same cycle, and that `core_ret` comes only after a matching acknowledge. The bench drives the acknowledge only after it has seen the request at the ports. It issues exactly one return per acknowledge. It keeps these strobes one cycle wide, in cycles of their own.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NCORE  = 3;
  localparam int unsigned ID_RST = 0;
  localparam int unsigned ID_EMU = 1;
  localparam int unsigned ID_PWR = 2;
  localparam int unsigned CTRL_NEST = 4;
  localparam int unsigned CTRL_GIE  = 5;

  typedef enum logic [1:0] {
    A_LATCH = 2'd0,
    A_MASK  = 2'd1,
    A_CTRL  = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  // Rank of a source ID: core sources first, peripherals saturate at maxlvl.
  function automatic int unsigned src_rank(int unsigned id, int unsigned maxlvl);
    if (id < NCORE) return id;
    else if (id - NCORE > maxlvl) return NCORE + maxlvl;
    else return id;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 19,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_irq,
  input  logic [NSRC-1:0] ack_clr,
  input  logic [1:0]      addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] latch_q,
  output logic [NSRC-1:0] mask_q,
  output logic            gie_q,
  output logic            nest_q,
  output logic [DW-1:0]   rdata
);
  reg_addr_e       sel;
  logic [NSRC-1:0] base;
  logic [NSRC-1:0] latch_n;
  logic [DW-1:0]   rd_n;

  assign sel = reg_addr_e'(addr);

  always_comb begin
    base    = (wr && sel == A_LATCH) ? wdata[NSRC-1:0] : latch_q;
    latch_n = (base & ~ack_clr) | src_irq;
  end

  always_comb begin
    rd_n = '0;
    case (sel)
      A_LATCH: rd_n = DW'(latch_q);
      A_MASK:  rd_n = DW'(mask_q);
      A_CTRL: begin
        rd_n[CTRL_GIE]  = gie_q;
        rd_n[CTRL_NEST] = nest_q;
      end
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      mask_q  <= '0;
      gie_q   <= 1'b0;
      nest_q  <= 1'b0;
      rdata   <= '0;
    end else begin
      latch_q <= latch_n;
      rdata   <= rd_n;
      if (wr && sel == A_MASK) mask_q <= wdata[NSRC-1:0];
      if (wr && sel == A_CTRL) begin
        gie_q  <= wdata[CTRL_GIE];
        nest_q <= wdata[CTRL_NEST];
      end
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 19,
  parameter int unsigned MAXLVL = 11,
  parameter int unsigned VW     = 5,
  parameter int unsigned RW     = 4
) (
  input  logic [NSRC-1:0] latch_q,
  input  logic [NSRC-1:0] mask_q,
  input  logic            gie,
  input  logic            nest,
  input  logic            svc_active,
  input  logic [RW-1:0]   svc_rank,
  output logic            fire,
  output logic [VW-1:0]   vec,
  output logic [RW-1:0]   vec_rank
);
  logic [NSRC-1:0] elig;
  logic [RW-1:0]   rank_of [NSRC];
  logic            found;
  logic            allowed;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int unsigned RANK_I = src_rank(i, MAXLVL);
    assign rank_of[i] = RW'(RANK_I);
    if (i == ID_RST || i == ID_EMU) begin : g_nmi
      assign elig[i] = latch_q[i];
    end else if (i == ID_PWR) begin : g_pwr
      assign elig[i] = latch_q[i] & gie;
    end else begin : g_per
      assign elig[i] = latch_q[i] & mask_q[i] & gie;
    end
  end

  always_comb begin
    found    = 1'b0;
    vec      = '0;
    vec_rank = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || rank_of[i] < vec_rank)) begin
        found    = 1'b1;
        vec      = VW'(i);
        vec_rank = rank_of[i];
      end
    end
    allowed = !svc_active || (nest && vec_rank < svc_rank);
    fire    = found && allowed;
  end
endmodule

// File: rtl/irq_service.sv
module irq_service #(
  parameter int unsigned RW    = 4,
  parameter int unsigned DEPTH = 15,
  parameter int unsigned DPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [RW-1:0]  push_rank,
  input  logic           pop,
  output logic           active,
  output logic [RW-1:0]  rank,
  output logic [DPW-1:0] depth
);
  logic [RW:0] stk [DEPTH];
  logic        do_push;
  logic        do_pop;

  assign do_push = push && (depth < DPW'(DEPTH));
  assign do_pop  = !push && pop && (depth != '0);

  always_ff @(posedge clk) begin
    if (do_push) stk[depth] <= {active, rank};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      rank   <= '0;
      depth  <= '0;
    end else if (do_push) begin
      active <= 1'b1;
      rank   <= push_rank;
      depth  <= depth + 1'b1;
    end else if (do_pop) begin
      {active, rank} <= stk[depth - 1'b1];
      depth          <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NPERIPH = 16,
  parameter int unsigned MAXLVL  = 11,
  parameter int unsigned DW      = 32,
  localparam int unsigned NSRC   = NCORE + NPERIPH,
  localparam int unsigned VW     = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_irq,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            core_ack,
  input  logic            core_ret,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec
);
  localparam int unsigned NRANK = NCORE + MAXLVL + 1;
  localparam int unsigned RW    = $clog2(NRANK);
  localparam int unsigned DPW   = $clog2(NRANK + 1);

  logic [NSRC-1:0] latch_q, mask_q, ack_clr;
  logic            gie, nest, fire, ack_ok;
  logic            svc_active;
  logic [RW-1:0]   svc_rank, sel_rank, irq_rank;
  logic [VW-1:0]   sel_vec;
  logic [DPW-1:0]  svc_depth;

  assign ack_ok  = core_ack & irq_req;
  assign ack_clr = ack_ok ? (NSRC'(1) << irq_vec) : '0;

  irq_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .src_irq(src_irq), .ack_clr(ack_clr),
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .latch_q(latch_q), .mask_q(mask_q), .gie_q(gie), .nest_q(nest),
    .rdata(reg_rdata)
  );

  irq_select #(.NSRC(NSRC), .MAXLVL(MAXLVL), .VW(VW), .RW(RW)) u_sel (
    .latch_q(latch_q), .mask_q(mask_q), .gie(gie), .nest(nest),
    .svc_active(svc_active), .svc_rank(svc_rank),
    .fire(fire), .vec(sel_vec), .vec_rank(sel_rank)
  );

  irq_service #(.RW(RW), .DEPTH(NRANK), .DPW(DPW)) u_svc (
    .clk(clk), .rst(rst), .push(ack_ok), .push_rank(irq_rank),
    .pop(core_ret), .active(svc_active), .rank(svc_rank), .depth(svc_depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      irq_rank <= '0;
    end else begin
      irq_req  <= fire & ~ack_ok;
      irq_vec  <= sel_vec;
      irq_rank <= sel_rank;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 19,
  parameter int unsigned MAXLVL = 11,
  parameter int unsigned VW     = 5,
  parameter int unsigned RW     = 4,
  parameter int unsigned DPW    = 4,
  parameter int unsigned DEPTH  = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec,
  input logic            core_ack,
  input logic [NSRC-1:0] latch_q,
  input logic            gie,
  input logic            nest,
  input logic            svc_active,
  input logic [RW-1:0]   svc_rank,
  input logic [DPW-1:0]  svc_depth
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !irq_req);

  assert_vec_pending_R2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(latch_q) & (NSRC'(1) << irq_vec)) != '0);

  assert_gie_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(gie)) |-> (irq_vec == VW'(ID_RST) || irq_vec == VW'(ID_EMU)));

  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (core_ack && irq_req) |=> !irq_req);

  assert_nest_higher_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_req && $past(svc_active)) |->
      (RW'(src_rank(int'(irq_vec), MAXLVL)) < $past(svc_rank)));

  assert_seq_block_R11: assert property (@(posedge clk) disable iff (rst)
    (svc_active && !nest) |=> !irq_req);

  assert_stack_bound_R12: assert property (@(posedge clk) disable iff (rst)
    (svc_depth <= DPW'(DEPTH)) && (svc_active == (svc_depth != '0)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .NSRC(NSRC), .MAXLVL(MAXLVL), .VW(VW), .RW(RW), .DPW(DPW), .DEPTH(NRANK)
) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
  .core_ack(core_ack), .latch_q(latch_q), .gie(gie), .nest(nest),
  .svc_active(svc_active), .svc_rank(svc_rank), .svc_depth(svc_depth)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int NSRC = 19;
  localparam int VW   = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_irq = '0;
  logic [1:0]      reg_addr = 2'd3;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            core_ack = 1'b0;
  logic            core_ret = 1'b0;
  logic            irq_req;
  logic [VW-1:0]   irq_vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .src_irq(src_irq), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_ack(core_ack), .core_ret(core_ret), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = a[1:0]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = a[1:0];
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input int id);
    @(negedge clk);
    src_irq = NSRC'(1) << id;
    @(negedge clk);
    src_irq = '0;
  endtask

  task automatic ack(input string tag);
    @(negedge clk);
    core_ack = 1'b1;
    @(negedge clk);
    core_ack = 1'b0;
    chk({tag, " req low after ack"}, irq_req, 0);
  endtask

  task automatic ret();
    @(negedge clk);
    core_ret = 1'b1;
    @(negedge clk);
    core_ret = 1'b0;
  endtask

  task automatic expect_vec(input string tag, input int v);
    settle();
    chk({tag, " req"}, irq_req, 1);
    chk({tag, " vec"}, irq_vec, v);
  endtask

  task automatic expect_none(input string tag);
    settle();
    chk({tag, " no req"}, irq_req, 0);
  endtask

  task automatic t_reset();
    int d;
    chk("R1 req", irq_req, 0);
    rd(0, d); chk("R1 latch", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    rd(2, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_ctrl();
    int d;
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R7 reserved bits read 0", d, 32'h30);
    wr(2, 32'h0000_FFCF);
    rd(2, d); chk("R7 only enables stored", d, 0);
  endtask

  task automatic t_latch();
    int d;
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'h50);
    rd(0, d); chk("R8 force pending", d, 32'h50);
    expect_none("R5 gie off");
    rd(0, d); chk("R5 pending kept", d, 32'h50);
    wr(0, 0);
    rd(0, d); chk("R8 clear pending", d, 0);
  endtask

  task automatic t_mask();
    int d;
    wr(1, 0);
    wr(2, 32'h20);
    pulse(5);
    expect_none("R2 masked");
    rd(0, d); chk("R2 latched", d, 32'h20);
    wr(1, 32'h20);
    expect_vec("R2 unmasked", 5);
    ack("R9");
    rd(0, d); chk("R9 pending cleared", d, 0);
    ret();
    expect_none("R12 idle after return");
  endtask

  task automatic t_pwr();
    wr(2, 0);
    wr(1, 0);
    pulse(2);
    expect_none("R4 gie off blocks power-down");
    wr(2, 32'h20);
    expect_vec("R4 power-down mask ignored", 2);
    ack("R4"); ret();
  endtask

  task automatic t_core();
    wr(2, 0);
    pulse(1);
    expect_vec("R3 emulation", 1);
    ack("R3"); ret();
    pulse(0);
    expect_vec("R3 reset source", 0);
    ack("R3"); ret();
  endtask

  task automatic t_prio();
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'h20);
    wr(0, (1 << 10) | (1 << 15) | (1 << 16));
    expect_vec("R6 lowest rank", 10);
    ack("R6"); ret();
    expect_vec("R6 tie lower id", 15);
    ack("R6"); ret();
    expect_vec("R6 last", 16);
    ack("R6"); ret();
    expect_none("R6 drained");
  endtask

  task automatic t_nest();
    wr(2, 32'h30);
    pulse(12);
    expect_vec("R10 first", 12);
    ack("R10");
    pulse(14);
    expect_none("R10 lower waits");
    pulse(6);
    expect_vec("R10 preempt", 6);
    ack("R10");
    ret();
    expect_none("R12 restored level blocks");
    ret();
    expect_vec("R12 after unwind", 14);
    ack("R12"); ret();
  endtask

  task automatic t_seq();
    wr(2, 32'h20);
    pulse(9);
    expect_vec("R11 first", 9);
    ack("R11");
    pulse(4);
    expect_none("R11 sequential");
    ret();
    expect_vec("R11 after return", 4);
    ack("R11"); ret();
  endtask

  task automatic t_same();
    int d;
    wr(2, 0);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 0; reg_wr = 1'b1;
    src_irq = NSRC'(1) << 7;
    @(negedge clk);
    reg_wr = 1'b0; src_irq = '0;
    rd(0, d); chk("R13 request kept over write", d, 32'h80);
    wr(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_latch();
    t_mask();
    t_pwr();
    t_core();
    t_prio();
    t_nest();
    t_seq();
    t_same();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule